// File: doc/BRIEF.md
# Variable Pulse Width Frame Receiver

This block listens to a single-wire bus on which every bit is one level segment, and the bit value depends on both the level and the length of that segment. The raw line is brought into the clock domain through two flops, cleaned of short spikes, and the length of every clean segment is measured in clock cycles. Each measured segment falls into one of four classes: short symbol, long symbol, frame marker or out of range. A long high marker opens a frame. The level and class of each following segment give one bit. Bits are packed into bytes, and a low segment that stays low for the marker length closes the frame.

Received bytes leave as a stream of single-cycle strobes. The header byte carries a first flag and the check byte carries a last flag. When the frame closes, exactly one status strobe reports the result: good frame, bad check byte, symbol out of range, incomplete byte or too many bytes. Widths are set in microseconds and scaled by a clock-rate parameter, so the same block serves any clock that is a whole number of megahertz.

Top module: `vpw_frame_rx`

## Requirements
- R1: While reset is held and in the cycles after its release, every output stays low until a frame has been received.
- R2: A pulse on the line shorter than GLITCH_CYC clock cycles changes no segment width and no output.
- R3: Outside a frame, only a high segment of 164 to 239 us opens a frame. Every other segment, including a high segment of 240 us, is ignored and produces no output.
- R4: Inside a frame, a segment of 34 to 96 us is short and a segment of 97 to 163 us is long. A low short segment is 0 and a low long segment is 1. A high short segment is 1 and a high long segment is 0.
- R5: Bits are packed most significant bit first. Each byte is issued on byte_data with a byte_valid strobe. The first byte of a frame carries byte_first, and the final byte carries byte_last.
- R6: A low segment that reaches 164 us closes the frame. If the final byte equals the bitwise inverse of the CRC-8 of all earlier bytes (polynomial 0x1D, preset 0xFF, processed MSB first), then frame_ok pulses in the same cycle as byte_last.
- R7: If that final byte does not match, err_crc pulses together with byte_last.
- R8: Inside a frame, a segment shorter than 34 us, a high segment of 164 us or more, or a segment longer than 239 us raises err_symbol. The frame is then dropped, with no byte_last and no frame_ok.
- R9: A frame that closes with a partial byte, or with fewer than two bytes, raises err_framing. It issues no byte_last.
- R10: When a byte beyond the MAX_BYTES-th (default 11) completes, err_overrun is raised and the frame is dropped. A dropped frame issues at most MAX_BYTES-1 bytes.
- R11: frame_ok, err_symbol, err_framing, err_crc and err_overrun are one-cycle pulses, never more than one at a time, and exactly one per opened frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vpw_line | input | 1 | Raw bus line, asynchronous to clk |
| byte_valid | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte |
| byte_first | output | 1 | Marks the header byte |
| byte_last | output | 1 | Marks the check byte |
| frame_ok | output | 1 | Frame closed with a matching check byte |
| err_symbol | output | 1 | Segment width out of range inside a frame |
| err_framing | output | 1 | Frame closed on a partial byte or fewer than two bytes |
| err_crc | output | 1 | Check byte mismatch |
| err_overrun | output | 1 | Too many bytes in a frame |

## Verification
A wrong bit counter or a wrong shift direction shows up as byte data that differs from the sent bytes on the very first byte_valid of the frame, and the check byte then fails as well. A class window that is off shows up at the first symbol near a window edge, as a spurious err_symbol or as a flipped bit. A wrong running CRC or a lost byte count appears only when the frame closes, as err_crc in place of frame_ok or as a missing status pulse. A frame state machine that fails to return to idle makes the next frame produce no output at all.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

  typedef enum logic [1:0] {
    SEG_SHORT = 2'd0,
    SEG_LONG  = 2'd1,
    SEG_MARK  = 2'd2,
    SEG_BAD   = 2'd3
  } seg_cls_t;

  // One byte through CRC-8, polynomial x^8+x^4+x^3+x^2+1, MSB first.
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] data);
    logic [7:0] c;
    c = crc ^ data;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ({c[6:0], 1'b0} ^ 8'h1D) : {c[6:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/vpw_line_filter.sv
module vpw_line_filter #(
  parameter int GLITCH_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic lvl
);
  localparam int CW = (GLITCH_CYC < 2) ? 1 : $clog2(GLITCH_CYC);

  logic          sync_a, sync_b;
  logic [CW-1:0] run_q, run_n;
  logic          lvl_n;

  always_comb begin
    run_n = run_q;
    lvl_n = lvl;
    if (sync_b == lvl) begin
      run_n = '0;
    end else if (run_q == CW'(GLITCH_CYC - 1)) begin
      lvl_n = sync_b;
      run_n = '0;
    end else begin
      run_n = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      run_q  <= '0;
      lvl    <= 1'b0;
    end else begin
      sync_a <= line_in;
      sync_b <= sync_a;
      run_q  <= run_n;
      lvl    <= lvl_n;
    end
  end
endmodule

// File: rtl/vpw_width_meter.sv
module vpw_width_meter import vpw_pkg::*; #(
  parameter int TICKS_PER_US = 1,
  parameter int SHORT_MIN_US = 34,
  parameter int LONG_MIN_US  = 97,
  parameter int MARK_MIN_US  = 164,
  parameter int MARK_MAX_US  = 239
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lvl,
  output logic     seg_stb,
  output logic     seg_lvl,
  output seg_cls_t seg_cls,
  output logic     eod_stb
);
  localparam int SHORT_MIN_C = SHORT_MIN_US * TICKS_PER_US;
  localparam int LONG_MIN_C  = LONG_MIN_US  * TICKS_PER_US;
  localparam int MARK_MIN_C  = MARK_MIN_US  * TICKS_PER_US;
  localparam int MARK_MAX_C  = MARK_MAX_US  * TICKS_PER_US;
  localparam int SAT_C       = MARK_MAX_C + 1;
  localparam int CW          = $clog2(SAT_C + 1);

  logic          prev_q;
  logic [CW-1:0] run_q, run_n;
  logic          edge_w;
  logic          stb_n, lvl_n, eod_n;
  seg_cls_t      cls_n;

  function automatic seg_cls_t classify(input logic [CW-1:0] w);
    int v;
    v = int'(w);
    if (v < SHORT_MIN_C)      return SEG_BAD;
    else if (v < LONG_MIN_C)  return SEG_SHORT;
    else if (v < MARK_MIN_C)  return SEG_LONG;
    else if (v <= MARK_MAX_C) return SEG_MARK;
    else                      return SEG_BAD;
  endfunction

  assign edge_w = (lvl != prev_q);

  always_comb begin
    if (edge_w)                    run_n = CW'(1);
    else if (run_q != CW'(SAT_C))  run_n = run_q + 1'b1;
    else                           run_n = run_q;
    stb_n = edge_w;
    lvl_n = edge_w ? prev_q : seg_lvl;
    cls_n = edge_w ? classify(run_q) : seg_cls;
    eod_n = !lvl && !edge_w && (run_q == CW'(MARK_MIN_C - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      run_q   <= '0;
      seg_stb <= 1'b0;
      seg_lvl <= 1'b0;
      seg_cls <= SEG_BAD;
      eod_stb <= 1'b0;
    end else begin
      prev_q  <= lvl;
      run_q   <= run_n;
      seg_stb <= stb_n;
      seg_lvl <= lvl_n;
      seg_cls <= cls_n;
      eod_stb <= eod_n;
    end
  end
endmodule

// File: rtl/vpw_frame_dec.sv
module vpw_frame_dec import vpw_pkg::*; #(
  parameter int MAX_BYTES = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seg_stb,
  input  logic       seg_lvl,
  input  seg_cls_t   seg_cls,
  input  logic       eod_stb,
  output logic       o_valid,
  output logic [7:0] o_data,
  output logic       o_first,
  output logic       o_last,
  output logic       o_ok,
  output logic       o_err_sym,
  output logic       o_err_frm,
  output logic       o_err_crc,
  output logic       o_err_ovr
);
  localparam int NBW = $clog2(MAX_BYTES + 1);

  typedef enum logic {ST_IDLE, ST_BODY} st_t;

  st_t            st_q, st_n;
  logic [7:0]     sh_q, sh_n;
  logic [2:0]     bit_q, bit_n;
  logic [NBW-1:0] nb_q, nb_n;
  logic [7:0]     pend_q, pend_n;
  logic           pf_q, pf_n;
  logic [7:0]     crc_q, crc_n;
  logic           v_n, f_n, l_n, ok_n, es_n, ef_n, ec_n, eo_n;
  logic [7:0]     d_n;
  logic           bit_v;

  assign bit_v = seg_lvl ? (seg_cls == SEG_SHORT) : (seg_cls == SEG_LONG);

  always_comb begin
    st_n = st_q; sh_n = sh_q; bit_n = bit_q; nb_n = nb_q;
    pend_n = pend_q; pf_n = pf_q; crc_n = crc_q;
    v_n = 1'b0; d_n = o_data; f_n = 1'b0; l_n = 1'b0;
    ok_n = 1'b0; es_n = 1'b0; ef_n = 1'b0; ec_n = 1'b0; eo_n = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (seg_stb && seg_lvl && seg_cls == SEG_MARK) begin
          st_n  = ST_BODY;
          bit_n = '0;
          nb_n  = '0;
          crc_n = 8'hFF;
          pf_n  = 1'b1;
        end
      end
      ST_BODY: begin
        if (seg_stb) begin
          if (seg_cls == SEG_SHORT || seg_cls == SEG_LONG) begin
            sh_n  = {sh_q[6:0], bit_v};
            bit_n = bit_q + 1'b1;
            if (bit_q == 3'd7) begin
              if (nb_q == NBW'(MAX_BYTES)) begin
                eo_n = 1'b1;
                st_n = ST_IDLE;
              end else begin
                nb_n   = nb_q + 1'b1;
                pend_n = sh_n;
                if (nb_q != '0) begin
                  v_n   = 1'b1;
                  d_n   = pend_q;
                  f_n   = pf_q;
                  pf_n  = 1'b0;
                  crc_n = crc8_step(crc_q, pend_q);
                end
              end
            end
          end else begin
            es_n = 1'b1;
            st_n = ST_IDLE;
          end
        end else if (eod_stb) begin
          st_n = ST_IDLE;
          if (bit_q != '0 || int'(nb_q) < 2) begin
            ef_n = 1'b1;
          end else begin
            v_n  = 1'b1;
            d_n  = pend_q;
            l_n  = 1'b1;
            ok_n = (pend_q == ~crc_q);
            ec_n = (pend_q != ~crc_q);
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; sh_q <= '0; bit_q <= '0; nb_q <= '0;
      pend_q <= '0; pf_q <= 1'b0; crc_q <= '0;
      o_valid <= 1'b0; o_data <= '0; o_first <= 1'b0; o_last <= 1'b0;
      o_ok <= 1'b0; o_err_sym <= 1'b0; o_err_frm <= 1'b0;
      o_err_crc <= 1'b0; o_err_ovr <= 1'b0;
    end else begin
      st_q <= st_n; sh_q <= sh_n; bit_q <= bit_n; nb_q <= nb_n;
      pend_q <= pend_n; pf_q <= pf_n; crc_q <= crc_n;
      o_valid <= v_n; o_data <= d_n; o_first <= f_n; o_last <= l_n;
      o_ok <= ok_n; o_err_sym <= es_n; o_err_frm <= ef_n;
      o_err_crc <= ec_n; o_err_ovr <= eo_n;
    end
  end
endmodule

// File: rtl/vpw_frame_rx.sv
module vpw_frame_rx import vpw_pkg::*; #(
  parameter int TICKS_PER_US = 1,
  parameter int GLITCH_CYC   = 3,
  parameter int MAX_BYTES    = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vpw_line,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       byte_first,
  output logic       byte_last,
  output logic       frame_ok,
  output logic       err_symbol,
  output logic       err_framing,
  output logic       err_crc,
  output logic       err_overrun
);
  logic     rst_a, rst_b;
  logic     lvl;
  logic     seg_stb, seg_lvl, eod_stb;
  seg_cls_t seg_cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a <= 1'b0;
      rst_b <= 1'b0;
    end else begin
      rst_a <= 1'b1;
      rst_b <= rst_a;
    end
  end

  vpw_line_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
    .clk(clk), .rst_n(rst_b), .line_in(vpw_line), .lvl(lvl)
  );

  vpw_width_meter #(.TICKS_PER_US(TICKS_PER_US)) u_meter (
    .clk(clk), .rst_n(rst_b), .lvl(lvl),
    .seg_stb(seg_stb), .seg_lvl(seg_lvl), .seg_cls(seg_cls), .eod_stb(eod_stb)
  );

  vpw_frame_dec #(.MAX_BYTES(MAX_BYTES)) u_dec (
    .clk(clk), .rst_n(rst_b),
    .seg_stb(seg_stb), .seg_lvl(seg_lvl), .seg_cls(seg_cls), .eod_stb(eod_stb),
    .o_valid(byte_valid), .o_data(byte_data), .o_first(byte_first), .o_last(byte_last),
    .o_ok(frame_ok), .o_err_sym(err_symbol), .o_err_frm(err_framing),
    .o_err_crc(err_crc), .o_err_ovr(err_overrun)
  );
endmodule

// File: rtl/vpw_rx_checker.sv
module vpw_rx_checker #(
  parameter int MAX_BYTES = 11
) (
  input logic clk,
  input logic rst_n,
  input logic byte_valid,
  input logic byte_first,
  input logic byte_last,
  input logic frame_ok,
  input logic err_symbol,
  input logic err_framing,
  input logic err_crc,
  input logic err_overrun
);
  logic       open_q;
  logic [7:0] cnt_q;
  logic       any_st;

  assign any_st = frame_ok | err_symbol | err_framing | err_crc | err_overrun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (any_st) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (byte_valid) begin
      open_q <= 1'b1;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_ok, err_symbol, err_framing, err_crc, err_overrun})); // R11
  AST_STATUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    any_st |=> !any_st); // R11
  AST_OK_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> (byte_valid && byte_last)); // R6
  AST_LAST_HAS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    byte_last |-> (byte_valid && (frame_ok || err_crc))); // R7
  AST_FIRST_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_first) |-> !open_q); // R5
  AST_MID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_first) |-> open_q); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (int'(cnt_q) < MAX_BYTES)); // R10
endmodule

bind vpw_frame_rx vpw_rx_checker #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_first(byte_first),
  .byte_last(byte_last), .frame_ok(frame_ok), .err_symbol(err_symbol),
  .err_framing(err_framing), .err_crc(err_crc), .err_overrun(err_overrun)
);

// File: tb/sim_vpw_frame_rx.sv
module sim_vpw_frame_rx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic byte_valid, byte_first, byte_last;
  logic [7:0] byte_data;
  logic frame_ok, err_symbol, err_framing, err_crc, err_overrun;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpw_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .vpw_line(line),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_first(byte_first),
    .byte_last(byte_last), .frame_ok(frame_ok), .err_symbol(err_symbol),
    .err_framing(err_framing), .err_crc(err_crc), .err_overrun(err_overrun)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] cap [0:15];
  bit capf [0:15];
  bit capl [0:15];
  int ncap, n_ok, n_sym, n_frm, n_crc, n_ovr;
  logic [7:0] fb [0:15];
  int fn;
  bit lv;
  bit jit_on, glitch_on;
  int sh_ov, lg_ov, sof_w;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid && ncap < 16) begin
        cap[ncap] = byte_data; capf[ncap] = byte_first; capl[ncap] = byte_last;
        ncap++;
      end
      if (frame_ok) n_ok++;
      if (err_symbol) n_sym++;
      if (err_framing) n_frm++;
      if (err_crc) n_crc++;
      if (err_overrun) n_ovr++;
    end
  end

  task automatic chk(input bit good, input string req, input int act, input int exp);
    total++;
    if (!good) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input int n);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ fb[i];
      for (int k = 0; k < 8; k++) c = c[7] ? ({c[6:0], 1'b0} ^ 8'h1D) : {c[6:0], 1'b0};
    end
    return ~c;
  endfunction

  function automatic int jit();
    return jit_on ? (int'($urandom_range(0, 40)) - 20) : 0;
  endfunction

  task automatic seg(input bit l, input int n);
    if (glitch_on && n > 20) begin
      line = l;  repeat (8) @(negedge clk);
      line = !l; repeat (2) @(negedge clk);
      line = l;  repeat (n - 10) @(negedge clk);
    end else begin
      line = l; repeat (n) @(negedge clk);
    end
  endtask

  task automatic send_bit(input bit b);
    bit is_short;
    int w;
    is_short = lv ? b : !b;
    if (is_short) w = (sh_ov != 0) ? sh_ov : 64 + jit();
    else          w = (lg_ov != 0) ? lg_ov : 128 + jit();
    seg(lv, w);
    lv = !lv;
  endtask

  task automatic send_frame(input int nbytes, input int extra_bits);
    ncap = 0; n_ok = 0; n_sym = 0; n_frm = 0; n_crc = 0; n_ovr = 0;
    seg(1'b1, (sof_w != 0) ? sof_w : 200 + jit());
    lv = 1'b0;
    for (int i = 0; i < nbytes; i++)
      for (int k = 7; k >= 0; k--) send_bit(fb[i][k]);
    for (int k = 0; k < extra_bits; k++) send_bit(k[0]);
    line = 1'b0;
    repeat (400) @(negedge clk);
  endtask

  task automatic make_frame(input int n);
    fn = n;
    for (int i = 0; i < n - 1; i++) fb[i] = 8'($urandom);
    fb[n-1] = crc8(n - 1);
  endtask

  task automatic expect_good(input string req);
    chk(ncap == fn, req, ncap, fn);
    for (int i = 0; i < fn && i < ncap; i++) begin
      chk(cap[i] == fb[i], req, cap[i], fb[i]);
      chk(capf[i] == (i == 0), req, capf[i], i == 0);
      chk(capl[i] == (i == fn - 1), req, capl[i], i == fn - 1);
    end
    chk(n_ok == 1 && n_sym + n_frm + n_crc + n_ovr == 0, {req, " R11"}, n_ok, 1);
  endtask

  initial begin
    sh_ov = 0; lg_ov = 0; sof_w = 0; jit_on = 0; glitch_on = 0;
    ncap = 0; n_ok = 0; n_sym = 0; n_frm = 0; n_crc = 0; n_ovr = 0;
    void'($urandom(32'h5EED1));
    repeat (5) @(negedge clk);
    chk(!byte_valid && !frame_ok && !err_symbol && !err_framing && !err_crc && !err_overrun,
        "R1 in reset", byte_valid, 0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    chk(ncap == 0 && n_ok + n_sym + n_frm + n_crc + n_ovr == 0, "R1 after release", ncap, 0);

    // Directed nominal frame, known pattern, MSB first
    fn = 3; fb[0] = 8'hA5; fb[1] = 8'h3C; fb[2] = crc8(2);
    send_frame(3, 0);
    expect_good("R4 R5 R6 directed");

    // Random frames with width jitter
    jit_on = 1;
    for (int f = 0; f < 6; f++) begin
      make_frame(int'($urandom_range(2, 11)));
      send_frame(fn, 0);
      expect_good("R4 R5 R6 random");
    end
    jit_on = 0;

    // Window edges
    sh_ov = 96; lg_ov = 97; make_frame(4); send_frame(fn, 0); expect_good("R4 edge 96/97");
    sh_ov = 34; lg_ov = 163; sof_w = 164; make_frame(3); send_frame(fn, 0); expect_good("R4 R3 edge 34/163/164");
    sh_ov = 0; lg_ov = 0; sof_w = 239; make_frame(2); send_frame(fn, 0); expect_good("R3 marker 239");

    // Too long start marker: ignored
    sof_w = 240; make_frame(3); send_frame(fn, 0);
    chk(ncap == 0 && n_ok + n_sym + n_frm + n_crc + n_ovr == 0, "R3 240us ignored", ncap, 0);
    sof_w = 0;

    // Short symbol too short
    sh_ov = 33; make_frame(3); send_frame(fn, 0);
    chk(n_sym == 1 && n_ok == 0 && n_frm + n_crc + n_ovr == 0, "R8 R11 33us", n_sym, 1);
    chk(ncap == 0, "R8 no bytes", ncap, 0);
    sh_ov = 0;

    // Recovery after error
    make_frame(5); send_frame(fn, 0); expect_good("R8 recovery");

    // Wrong check byte
    make_frame(4); fb[3] = fb[3] ^ 8'h01; send_frame(fn, 0);
    chk(n_crc == 1 && n_ok == 0 && n_sym + n_frm + n_ovr == 0, "R7 R11 crc", n_crc, 1);
    chk(ncap == 4 && capl[3] && cap[3] == fb[3], "R7 last byte", ncap, 4);

    // Partial byte
    make_frame(4); send_frame(fn, 6);
    chk(n_frm == 1 && n_ok + n_sym + n_crc + n_ovr == 0, "R9 R11 partial", n_frm, 1);
    chk(ncap == 3, "R9 bytes before", ncap, 3);
    for (int i = 0; i < ncap; i++) chk(!capl[i], "R9 no last", capl[i], 0);

    // Single byte frame
    fn = 1; fb[0] = 8'h5A; send_frame(1, 0);
    chk(n_frm == 1 && ncap == 0 && n_ok == 0, "R9 one byte", n_frm, 1);

    // Overrun
    make_frame(12); send_frame(fn, 0);
    chk(n_ovr == 1 && n_ok + n_sym + n_frm + n_crc == 0, "R10 R11 overrun", n_ovr, 1);
    chk(ncap == 10, "R10 bytes before", ncap, 10);

    // Largest legal frame
    make_frame(11); send_frame(fn, 0); expect_good("R10 eleven bytes");

    // Spikes inside every segment
    glitch_on = 1; make_frame(5); send_frame(fn, 0); expect_good("R2 spikes");
    glitch_on = 0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule